// File: doc/BRIEF.md
# Partial-Width Register File

This block holds sixteen 64-bit general-purpose registers and lets every access pick a sub-field view of the target register. It has two combinational read ports and one write port. Each port carries three control fields: a register index, a 3-bit view code and a wide-mode flag.

A read returns the chosen field, zero-extended to 64 bits. A write merges its data into the stored value, and the view decides which bits change. Some views exist only for certain indices or only in wide mode. An access to a view that is not allowed raises an illegal flag on that port and has no effect.

The block belongs next to an instruction decoder that has already worked out the operand width and the mode. Decoding, flags and memory access stay outside it.

Top module: `regview_regfile`

## Requirements
- R1: A synchronous reset, sampled on the rising clock edge, clears all sixteen registers to zero.
- R2: View codes on a read: 0 gives the full 64 bits, 1 gives bits 31:0, 2 gives bits 15:0, 3 gives bits 7:0 and 4 gives bits 15:8. Every narrow result is zero-extended to 64 bits.
- R3: A legal write with view 1 stores wr_data[31:0] in bits 31:0 and clears bits 63:32. A legal write with view 0 stores all 64 bits.
- R4: A legal write with view 2 replaces only bits 15:0 with wr_data[15:0]. View 3 replaces only bits 7:0 with wr_data[7:0]. View 4 replaces only bits 15:8 with wr_data[7:0]. Every other bit of the register keeps its value.
- R5: View 4 is legal only for register indices 0 to 3.
- R6: View 3 on register indices 4 to 7 is legal only while the port's wide-mode flag is 1. On all other indices it is always legal. View codes 5, 6 and 7 are never legal.
- R7: A read with an illegal view drives its illegal output to 1 and its data output to zero. A legal read drives the illegal output to 0.
- R8: A write with wr_en at 1 and an illegal view drives wr_illegal to 1 and leaves every register unchanged.
- R9: A write takes effect at the rising clock edge. A read of the register being written in the same cycle returns the value it held before that edge.
- R10: The two read ports work independently. Each port decodes its own index, view and mode flag at the same time as the other.
- R11: While wr_en is 0, no register changes and wr_illegal is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_view | input | 3 | Read port A view code |
| rd_a_wide | input | 1 | Read port A wide-mode flag |
| rd_a_data | output | 64 | Read port A zero-extended field |
| rd_a_illegal | output | 1 | Read port A view not permitted |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_view | input | 3 | Read port B view code |
| rd_b_wide | input | 1 | Read port B wide-mode flag |
| rd_b_data | output | 64 | Read port B zero-extended field |
| rd_b_illegal | output | 1 | Read port B view not permitted |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_view | input | 3 | Write view code |
| wr_wide | input | 1 | Write wide-mode flag |
| wr_data | input | 64 | Write data; narrow views use its low bits |
| wr_illegal | output | 1 | Write request rejected |

## Verification
The assertions check four properties on every cycle:
- An illegal read returns zero.
- A cycle with no write, or with a rejected write, leaves the whole register array untouched.
- A 32-bit write clears the upper half.
- A 16-bit read never carries bits above bit 15.

Only the bench's scenarios can show the rest:
- Which index, view and mode combinations are legal.
- That narrow merges keep exactly the right neighbouring bits.
- That a read in the same cycle as a write returns the old value.
- That the two read ports decode independently.

// File: rtl/regview_pkg.sv
package regview_pkg;

    typedef enum logic [2:0] {
        VW_FULL = 3'd0,
        VW_LO32 = 3'd1,
        VW_LO16 = 3'd2,
        VW_LO8  = 3'd3,
        VW_HI8  = 3'd4
    } view_e;

endpackage

// File: rtl/regview_legal.sv
module regview_legal
    import regview_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int HI_LIMIT = 4,
    parameter int GATE_LO  = 4,
    parameter int GATE_HI  = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [2:0]       view,
    input  logic             wide,
    output logic             legal
);

    logic in_gated;
    logic has_hi;

    always_comb begin
        in_gated = (int'(idx) >= GATE_LO) && (int'(idx) < GATE_HI);
        has_hi   = int'(idx) < HI_LIMIT;
        case (view)
            VW_FULL, VW_LO32, VW_LO16: legal = 1'b1;
            VW_LO8:                    legal = !in_gated || wide;
            VW_HI8:                    legal = has_hi;
            default:                   legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/regview_extract.sv
module regview_extract
    import regview_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] word,
    input  logic [2:0]      view,
    input  logic            legal,
    output logic [XLEN-1:0] field
);

    always_comb begin
        field = '0;
        if (legal) begin
            case (view)
                VW_FULL: field = word;
                VW_LO32: field = XLEN'(word[31:0]);
                VW_LO16: field = XLEN'(word[15:0]);
                VW_LO8:  field = XLEN'(word[7:0]);
                VW_HI8:  field = XLEN'(word[15:8]);
                default: field = '0;
            endcase
        end
    end

endmodule

// File: rtl/regview_merge.sv
module regview_merge
    import regview_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] old_word,
    input  logic [XLEN-1:0] wdata,
    input  logic [2:0]      view,
    output logic [XLEN-1:0] new_word
);

    always_comb begin
        case (view)
            VW_FULL: new_word = wdata;
            VW_LO32: new_word = XLEN'(wdata[31:0]);
            VW_LO16: new_word = {old_word[XLEN-1:16], wdata[15:0]};
            VW_LO8:  new_word = {old_word[XLEN-1:8], wdata[7:0]};
            VW_HI8:  new_word = {old_word[XLEN-1:16], wdata[7:0], old_word[7:0]};
            default: new_word = old_word;
        endcase
    end

endmodule

// File: rtl/regview_regfile.sv
module regview_regfile
    import regview_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int XLEN     = 64,
    parameter int HI_LIMIT = 4,
    parameter int GATE_LO  = 4,
    parameter int GATE_HI  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  rd_a_idx,
    input  logic [2:0]  rd_a_view,
    input  logic        rd_a_wide,
    output logic [63:0] rd_a_data,
    output logic        rd_a_illegal,
    input  logic [3:0]  rd_b_idx,
    input  logic [2:0]  rd_b_view,
    input  logic        rd_b_wide,
    output logic [63:0] rd_b_data,
    output logic        rd_b_illegal,
    input  logic        wr_en,
    input  logic [3:0]  wr_idx,
    input  logic [2:0]  wr_view,
    input  logic        wr_wide,
    input  logic [63:0] wr_data,
    output logic        wr_illegal
);

    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int NRD   = 2;

    typedef struct packed {
        logic [NUM_REGS-1:0][XLEN-1:0] regs;
    } state_t;

    state_t st_d, st_q;

    logic [NRD-1:0][IDX_W-1:0] rp_idx;
    logic [NRD-1:0][2:0]       rp_view;
    logic [NRD-1:0]            rp_wide;
    logic [NRD-1:0][XLEN-1:0]  rp_data;
    logic [NRD-1:0]            rp_legal;

    assign rp_idx[0]  = rd_a_idx;
    assign rp_view[0] = rd_a_view;
    assign rp_wide[0] = rd_a_wide;
    assign rp_idx[1]  = rd_b_idx;
    assign rp_view[1] = rd_b_view;
    assign rp_wide[1] = rd_b_wide;

    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            regview_legal #(
                .IDX_W(IDX_W), .HI_LIMIT(HI_LIMIT),
                .GATE_LO(GATE_LO), .GATE_HI(GATE_HI)
            ) u_legal (
                .idx(rp_idx[p]), .view(rp_view[p]),
                .wide(rp_wide[p]), .legal(rp_legal[p])
            );
            regview_extract #(.XLEN(XLEN)) u_extract (
                .word(st_q.regs[rp_idx[p]]), .view(rp_view[p]),
                .legal(rp_legal[p]), .field(rp_data[p])
            );

            AST_ILLEGAL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
                !rp_legal[p] |-> rp_data[p] == '0); // R7

            AST_HALF_READ_NARROW: assert property (@(posedge clk) disable iff (rst)
                (rp_legal[p] && rp_view[p] == VW_LO16) |-> rp_data[p][XLEN-1:16] == '0); // R2
        end
    endgenerate

    assign rd_a_data    = rp_data[0];
    assign rd_a_illegal = !rp_legal[0];
    assign rd_b_data    = rp_data[1];
    assign rd_b_illegal = !rp_legal[1];

    logic            wr_legal;
    logic            wr_go;
    logic [XLEN-1:0] wr_merged;

    regview_legal #(
        .IDX_W(IDX_W), .HI_LIMIT(HI_LIMIT),
        .GATE_LO(GATE_LO), .GATE_HI(GATE_HI)
    ) u_wr_legal (
        .idx(wr_idx), .view(wr_view), .wide(wr_wide), .legal(wr_legal)
    );

    regview_merge #(.XLEN(XLEN)) u_merge (
        .old_word(st_q.regs[wr_idx]), .wdata(wr_data),
        .view(wr_view), .new_word(wr_merged)
    );

    assign wr_go      = wr_en && wr_legal;
    assign wr_illegal = wr_en && !wr_legal;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (wr_go) begin
            st_d.regs[wr_idx] = wr_merged;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(st_q)); // R11

    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_illegal) |=> $stable(st_q)); // R8

    AST_W32_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_illegal && wr_view == VW_LO32)
            |=> st_q.regs[$past(wr_idx)][XLEN-1:32] == '0); // R3

endmodule

// File: tb/regview_regfile_tb.sv
module regview_regfile_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [2:0]  rd_a_view, rd_b_view, wr_view;
    logic        rd_a_wide, rd_b_wide, wr_wide, wr_en;
    logic [63:0] rd_a_data, rd_b_data, wr_data;
    logic        rd_a_illegal, rd_b_illegal, wr_illegal;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [63:0] model [16];

    always #5 clk = ~clk;

    regview_regfile u_dut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_view(rd_a_view), .rd_a_wide(rd_a_wide),
        .rd_a_data(rd_a_data), .rd_a_illegal(rd_a_illegal),
        .rd_b_idx(rd_b_idx), .rd_b_view(rd_b_view), .rd_b_wide(rd_b_wide),
        .rd_b_data(rd_b_data), .rd_b_illegal(rd_b_illegal),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_wide(wr_wide),
        .wr_data(wr_data), .wr_illegal(wr_illegal)
    );

    function automatic bit ok_view(int idx, int v, bit wide);
        case (v)
            0, 1, 2: return 1'b1;
            3:       return (idx >= 4 && idx < 8) ? wide : 1'b1;
            4:       return idx < 4;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [63:0] pick(logic [63:0] w, int v);
        case (v)
            0: return w;
            1: return w & 64'hFFFF_FFFF;
            2: return w & 64'hFFFF;
            3: return w & 64'hFF;
            4: return (w >> 8) & 64'hFF;
            default: return 64'h0;
        endcase
    endfunction

    function automatic logic [63:0] put(logic [63:0] o, logic [63:0] d, int v);
        case (v)
            0: return d;
            1: return d & 64'hFFFF_FFFF;
            2: return (o & ~64'hFFFF) | (d & 64'hFFFF);
            3: return (o & ~64'hFF) | (d & 64'hFF);
            4: return (o & ~64'hFF00) | ((d & 64'hFF) << 8);
            default: return o;
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int idx, int v, bit wide, logic [63:0] d, string req);
        bit ok;
        ok = ok_view(idx, v, wide);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_view = 3'(v); wr_wide = wide; wr_data = d;
        #1 chk(req, 64'(wr_illegal), 64'(!ok));
        @(negedge clk);
        wr_en = 1'b0;
        if (ok) model[idx] = put(model[idx], d, v);
    endtask

    task automatic rd_full(int idx, string req);
        rd_a_idx = 4'(idx); rd_a_view = 3'd0; rd_a_wide = 1'b1;
        #1 chk(req, rd_a_data, model[idx]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_view = '0; wr_wide = 1'b0; wr_data = '0;
        rd_a_idx = '0; rd_a_view = '0; rd_a_wide = 1'b0;
        rd_b_idx = '0; rd_b_view = '0; rd_b_wide = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = 64'h0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rd_full(i, "R1");
        end

        // preload distinct full-width patterns
        for (int i = 0; i < 16; i++)
            wr(i, 0, 1'b0, 64'hF0E1_D2C3_B4A5_9687 ^ ({16{4'(i)}} * 64'h1), "R3");

        // read sweep: every index, view and mode on both ports (R2 R5 R6 R7 R10)
        for (int i = 0; i < 16; i++)
            for (int v = 0; v < 8; v++)
                for (int m = 0; m < 2; m++) begin
                    int j;
                    bit oka, okb;
                    string tag;
                    j = i ^ 5;
                    @(negedge clk);
                    rd_a_idx = 4'(i); rd_a_view = 3'(v); rd_a_wide = m[0];
                    rd_b_idx = 4'(j); rd_b_view = 3'(7 - v); rd_b_wide = !m[0];
                    oka = ok_view(i, v, m[0]);
                    okb = ok_view(j, 7 - v, !m[0]);
                    tag = (v == 4) ? "R5" : (v == 3 && i >= 4 && i < 8) ? "R6" : "R2";
                    #1;
                    chk(tag, 64'(rd_a_illegal), 64'(!oka));
                    chk(oka ? tag : "R7", rd_a_data, oka ? pick(model[i], v) : 64'h0);
                    chk("R10", 64'(rd_b_illegal), 64'(!okb));
                    chk("R10", rd_b_data, okb ? pick(model[j], 7 - v) : 64'h0);
                end

        // write sweep: every index, view and mode, then full readback (R3 R4 R8)
        for (int i = 0; i < 16; i++)
            for (int v = 0; v < 8; v++)
                for (int m = 0; m < 2; m++) begin
                    logic [63:0] d;
                    string tag;
                    d = {8{8'(i * 16 + v * 2 + m + 1)}} ^ 64'h5A3C_96E1_0F87_2DB4;
                    tag = !ok_view(i, v, m[0]) ? "R8" : (v <= 1) ? "R3" : "R4";
                    wr(i, v, m[0], d, tag);
                    rd_full(i, tag);
                end

        // R11: wr_en low changes nothing
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 4'd6; wr_view = 3'd0; wr_data = 64'hDEAD_BEEF_0000_1111;
        #1 chk("R11", 64'(wr_illegal), 64'h0);
        @(negedge clk);
        rd_full(6, "R11");

        // R9: same-cycle read returns old value, new value after the edge
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd2; wr_view = 3'd0; wr_wide = 1'b0;
        wr_data = 64'h0123_4567_89AB_CDEF;
        rd_a_idx = 4'd2; rd_a_view = 3'd0;
        #1 chk("R9", rd_a_data, model[2]);
        @(posedge clk);
        #1 chk("R9", rd_a_data, 64'h0123_4567_89AB_CDEF);
        @(negedge clk) wr_en = 1'b0;
        model[2] = 64'h0123_4567_89AB_CDEF;

        // R1: reset in mid-run clears everything
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = 64'h0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rd_full(i, "R1");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule